// File: doc/BRIEF.md
# Tick Timer with Mode Control

This block is a 32-bit tick counter paired with a control word that selects how the counter behaves when its low bits reach a programmed period. Software reaches it through a small register access port with two registers: the control word (select 0) and the count (select 1). Writes take effect at the sampling clock edge. A read returns its data, registered, one cycle after the request.

The control word holds a 28-bit period, an interrupt-pending flag, an interrupt-enable flag and a 2-bit run mode. While a nonzero mode is held, a match occurs in every cycle where the low 28 count bits equal the period. With interrupts enabled, a match sets the pending flag, and the timer interrupt output follows that flag until software clears it. The counter is started or stopped only by a control write that actually changes the mode. A match can restart the count, halt it, or let it run on, depending on the mode.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the control word reads 0, the counter is stopped and `timer_irq` is low.
- R2: A control write whose mode field (bits [31:30]) differs from the held mode stops the counter when the new mode is 0 and starts it when the new mode is 1, 2 or 3.
- R3: A control write that leaves the mode field unchanged does not alter whether the counter runs.
- R4: The control word layout is period in [27:0], pending in 28, interrupt-enable in 29 and mode in [31:30]. A control write with bit 28 set keeps pending at its current value, and all other fields take the written value.
- R5: A control write with bit 28 clear clears pending, so `timer_irq` is low in the following cycle, even if a match would have set it in that cycle.
- R6: A write to the count register (select 1) loads the written value at that edge, taking priority over any increment, restart or hold.
- R7: A read request (valid high, write low) gives `rsp_vld` high in the next cycle, with `rsp_data` holding the selected register as it stood in the request cycle. `rsp_vld` is low in every other cycle.
- R8: While running, and absent a match that restarts or holds it, the count increases by one per clock and wraps from 0xFFFFFFFF to 0.
- R9: A match is a nonzero mode with count[27:0] equal to the period. A match with interrupt-enable set makes pending 1 at the next edge. `timer_irq` equals pending.
- R10: On a match while running, mode 1 reloads the count with 0, mode 2 holds the count and stops the counter, and mode 3 keeps incrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Register access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = control word, 1 = count |
| acc_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| timer_irq | output | 1 | Timer interrupt request (pending flag) |

## Verification
A wrong run flag shows up in the next count read as a value that has either moved when it should have held or held when it should have moved. The bench reads the count often enough that such an error appears within a few cycles. A corrupted pending flag or period shows on `timer_irq` one edge after the match, or one edge after the clearing write. The cycle-level model compares the interrupt line and every read response in each cycle, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        TT_OFF  = 2'd0,
        TT_WRAP = 2'd1,
        TT_HALT = 2'd2,
        TT_FREE = 2'd3
    } tt_mode_e;

    localparam int MODE_W = 2;
    localparam int FLAG_W = 2;
endpackage

// File: rtl/tt_cmp.sv
module tt_cmp #(
    parameter int PER_W = 28
) (
    input  logic [PER_W-1:0] cnt_low,
    input  logic [PER_W-1:0] period,
    input  tt_pkg::tt_mode_e mode,
    output logic             match
);
    always_comb begin
        match = (mode != tt_pkg::TT_OFF) && (cnt_low == period);
    end
endmodule

// File: rtl/tt_mode_reg.sv
module tt_mode_reg #(
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [PER_W+3:0] wdata,
    input  logic             match,
    output tt_pkg::tt_mode_e mode,
    output logic             ie,
    output logic             pend,
    output logic [PER_W-1:0] period,
    output logic             start_req,
    output logic             stop_req
);
    localparam int PEND_B = PER_W;
    localparam int IE_B   = PER_W + 1;
    localparam int MODE_L = PER_W + 2;

    typedef struct packed {
        tt_pkg::tt_mode_e mode;
        logic             ie;
        logic             pend;
        logic [PER_W-1:0] period;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    tt_pkg::tt_mode_e new_mode;
    logic hw_set;
    logic changed;

    always_comb begin
        new_mode  = tt_pkg::tt_mode_e'(wdata[MODE_L +: tt_pkg::MODE_W]);
        hw_set    = match && ctl_q.ie;
        changed   = wr && (new_mode != ctl_q.mode);
        start_req = changed && (new_mode != tt_pkg::TT_OFF);
        stop_req  = changed && (new_mode == tt_pkg::TT_OFF);
        ctl_d     = ctl_q;
        ctl_d.pend = ctl_q.pend | hw_set;
        if (wr) begin
            ctl_d.mode   = new_mode;
            ctl_d.ie     = wdata[IE_B];
            ctl_d.period = wdata[PER_W-1:0];
            if (!wdata[PEND_B]) begin
                ctl_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode   = ctl_q.mode;
    assign ie     = ctl_q.ie;
    assign pend   = ctl_q.pend;
    assign period = ctl_q.period;
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              match,
    input  tt_pkg::tt_mode_e  mode,
    output logic [DATA_W-1:0] cnt,
    output logic              run
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              run;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (ctr_q.run) begin
            if (match && mode == tt_pkg::TT_WRAP) begin
                ctr_d.cnt = '0;
            end else if (match && mode == tt_pkg::TT_HALT) begin
                ctr_d.run = 1'b0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
        if (load) begin
            ctr_d.cnt = load_val;
        end
        if (start_req) begin
            ctr_d.run = 1'b1;
        end else if (stop_req) begin
            ctr_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt = ctr_q.cnt;
    assign run = ctr_q.run;
endmodule

// File: rtl/tt_rd_port.sv
module tt_rd_port #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              sel,
    input  logic [DATA_W-1:0] ctl_word,
    input  logic [DATA_W-1:0] cnt,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = rd;
        if (rd) begin
            rsp_d.data = sel ? cnt : ctl_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld  = rsp_q.vld;
    assign rsp_data = rsp_q.data;
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data,
    output logic              timer_irq
);
    localparam int PER_W = DATA_W - tt_pkg::MODE_W - tt_pkg::FLAG_W;

    logic              ctl_wr, cnt_wr, rd_req;
    logic              match, ie, pend, start_req, stop_req, run_q;
    logic [PER_W-1:0]  period;
    logic [DATA_W-1:0] cnt_q, ctl_word;
    tt_pkg::tt_mode_e  mode_q;

    always_comb begin
        ctl_wr   = acc_vld && acc_wr && !acc_sel;
        cnt_wr   = acc_vld && acc_wr && acc_sel;
        rd_req   = acc_vld && !acc_wr;
        ctl_word = {mode_q, ie, pend, period};
    end

    tt_cmp #(.PER_W(PER_W)) cmp_i (
        .cnt_low(cnt_q[PER_W-1:0]),
        .period (period),
        .mode   (mode_q),
        .match  (match)
    );

    tt_mode_reg #(.PER_W(PER_W)) ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wdata    (acc_wdata),
        .match    (match),
        .mode     (mode_q),
        .ie       (ie),
        .pend     (pend),
        .period   (period),
        .start_req(start_req),
        .stop_req (stop_req)
    );

    tt_counter #(.DATA_W(DATA_W)) ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (acc_wdata),
        .start_req(start_req),
        .stop_req (stop_req),
        .match    (match),
        .mode     (mode_q),
        .cnt      (cnt_q),
        .run      (run_q)
    );

    tt_rd_port #(.DATA_W(DATA_W)) rdp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (rd_req),
        .sel     (acc_sel),
        .ctl_word(ctl_word),
        .cnt     (cnt_q),
        .rsp_vld (rsp_vld),
        .rsp_data(rsp_data)
    );

    assign timer_irq = pend;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_vld,
    input logic              acc_wr,
    input logic              acc_sel,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              rsp_vld,
    input logic              timer_irq,
    input logic [DATA_W-1:0] cnt_q,
    input logic              run_q,
    input logic              match,
    input logic [1:0]        mode_q
);
    localparam int PB = DATA_W - 4;

    logic ctl_w, cnt_w, rd_r;
    assign ctl_w = acc_vld && acc_wr && !acc_sel;
    assign cnt_w = acc_vld && acc_wr && acc_sel;
    assign rd_r  = acc_vld && !acc_wr;

    assert_stop_on_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && acc_wdata[DATA_W-1:DATA_W-2] == 2'd0) |=> !run_q);

    assert_keep_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && acc_wdata[PB] && timer_irq) |=> timer_irq);

    assert_clear_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !acc_wdata[PB]) |=> !timer_irq);

    assert_count_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w |=> cnt_q == $past(acc_wdata));

    assert_read_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_r |=> rsp_vld);

    assert_no_stray_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_r |=> !rsp_vld);

    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !match && !cnt_w) |=> cnt_q == $past(cnt_q) + 1'b1);

    assert_wrap_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && match && mode_q == 2'd1 && !cnt_w) |=> cnt_q == '0);

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && match && mode_q == 2'd2 && !cnt_w) |=> $stable(cnt_q));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_vld  (acc_vld),
    .acc_wr   (acc_wr),
    .acc_sel  (acc_sel),
    .acc_wdata(acc_wdata),
    .rsp_vld  (rsp_vld),
    .timer_irq(timer_irq),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .match    (match),
    .mode_q   (mode_q)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_sel = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        rsp_vld;
    logic [31:0] rsp_data;
    logic        timer_irq;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .rsp_vld(rsp_vld),
        .rsp_data(rsp_data), .timer_irq(timer_irq)
    );

    // Behavioural reference model
    logic [31:0] m_cnt, n_cnt, m_rdata;
    logic [27:0] m_per;
    logic [1:0]  m_mode, nm;
    logic        m_ie, m_pend, m_run, m_rvld, n_run, n_pend, hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_mode = 0; m_ie = 0; m_pend = 0;
            m_run = 0; m_rvld = 0; m_rdata = 0;
        end else begin
            hit = (m_mode != 0) && (m_cnt[27:0] == m_per);
            m_rvld = acc_vld && !acc_wr;
            if (m_rvld) m_rdata = acc_sel ? m_cnt : {m_mode, m_ie, m_pend, m_per};
            n_cnt = m_cnt; n_run = m_run;
            if (m_run) begin
                if (hit && m_mode == 2'd1) n_cnt = 0;
                else if (hit && m_mode == 2'd2) n_run = 0;
                else n_cnt = m_cnt + 1;
            end
            if (acc_vld && acc_wr && acc_sel) n_cnt = acc_wdata;
            n_pend = m_pend | (hit && m_ie);
            if (acc_vld && acc_wr && !acc_sel) begin
                nm = acc_wdata[31:30];
                if (nm != m_mode) n_run = (nm != 0);
                if (!acc_wdata[28]) n_pend = 0;
                m_mode = nm; m_ie = acc_wdata[29]; m_per = acc_wdata[27:0];
            end
            m_cnt = n_cnt; m_run = n_run; m_pend = n_pend;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (timer_irq !== m_pend) begin
                n_fail++;
                $display("FAIL R9 (%s): timer_irq=%0b expected %0b", cur_tag, timer_irq, m_pend);
            end
            n_chk++;
            if (rsp_vld !== m_rvld) begin
                n_fail++;
                $display("FAIL R7 (%s): rsp_vld=%0b expected %0b", cur_tag, rsp_vld, m_rvld);
            end else if (m_rvld) begin
                n_chk++;
                if (rsp_data !== m_rdata) begin
                    n_fail++;
                    $display("FAIL R7 (%s): rsp_data=%h expected %h", cur_tag, rsp_data, m_rdata);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic [1:0] md, input logic e,
                                       input logic p, input logic [27:0] per);
        return {md, e, p, per};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        acc_vld = 1; acc_wr = 1; acc_sel = sel; acc_wdata = d;
        @(negedge clk);
        acc_vld = 0; acc_wr = 0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        acc_vld = 1; acc_wr = 0; acc_sel = sel;
        @(negedge clk);
        acc_vld = 0;
        d = rsp_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] a, b;
        idle(4);
        rst_n = 1;
        idle(1);
        cur_tag = "R1";
        check("R1 irq after reset", {31'd0, timer_irq}, 32'd0);
        rd(0, a); check("R1 control word", a, 32'd0);
        idle(5);
        rd(1, a); check("R1 count stopped at 0", a, 32'd0);

        cur_tag = "R6";
        wr(1, 32'd100);
        rd(1, a); check("R6 count load", a, 32'd100);

        cur_tag = "R2";
        wr(0, mk(2'd3, 0, 0, 28'd1000));
        idle(10);
        rd(1, a); check("R2 started", {31'd0, a != 32'd100}, 32'd1);
        wr(0, mk(2'd0, 0, 0, 28'd1000));
        rd(1, a); idle(7); rd(1, b);
        check("R2 stopped holds count", b, a);

        cur_tag = "R3";
        wr(0, mk(2'd3, 0, 0, 28'd2000));
        idle(3);
        wr(0, mk(2'd3, 0, 0, 28'd3000));
        rd(1, a); idle(5); rd(1, b);
        check("R3 same-mode write keeps running", b, a + 32'd6);

        cur_tag = "R8";
        wr(1, 32'hFFFF_FFFE);
        rd(1, a); check("R8 before wrap", a, 32'hFFFF_FFFE);
        rd(1, a); check("R8 top value", a, 32'hFFFF_FFFF);
        rd(1, a); check("R8 wrapped to 0", a, 32'd0);

        cur_tag = "R10";
        wr(0, mk(2'd0, 0, 0, 28'd0));
        wr(1, 32'd0);
        wr(0, mk(2'd2, 1, 0, 28'd5));
        idle(15);
        rd(1, a); check("R10 halt mode holds at period", a, 32'd5);
        check("R9 match sets irq", {31'd0, timer_irq}, 32'd1);

        cur_tag = "R5";
        wr(0, mk(2'd2, 0, 0, 28'd5));
        check("R5 clear wins over match", {31'd0, timer_irq}, 32'd0);
        idle(3);
        check("R9 no set with enable off", {31'd0, timer_irq}, 32'd0);

        cur_tag = "R10";
        wr(0, mk(2'd0, 0, 0, 28'd0));
        wr(1, 32'd0);
        wr(0, mk(2'd1, 1, 0, 28'd3));
        idle(20);
        rd(1, a); check("R10 restart mode stays within period", {31'd0, a <= 32'd3}, 32'd1);
        check("R9 irq in restart mode", {31'd0, timer_irq}, 32'd1);
        wr(0, mk(2'd1, 0, 0, 28'd3));

        cur_tag = "R4";
        wr(0, mk(2'd0, 0, 0, 28'd0));
        wr(1, 32'd0);
        wr(0, mk(2'd3, 1, 0, 28'd10));
        idle(20);
        check("R9 free mode irq", {31'd0, timer_irq}, 32'd1);
        rd(1, a); check("R10 free mode runs past period", {31'd0, a > 32'd10}, 32'd1);
        wr(0, mk(2'd3, 1, 1, 28'd1000));
        check("R4 pending kept", {31'd0, timer_irq}, 32'd1);
        rd(0, a); check("R4 control fields", a, mk(2'd3, 1, 1, 28'd1000));
        wr(0, mk(2'd3, 1, 0, 28'd1000));
        check("R5 pending cleared", {31'd0, timer_irq}, 32'd0);
        rd(0, a); check("R4 control after clear", a, mk(2'd3, 1, 0, 28'd1000));

        idle(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule